// File: doc/BRIEF.md
# Sector Write-Protect Unlock Sequencer

This block sits next to a 256K x 16 word memory and watches every bus cycle for a fixed unlock pattern. The pattern is six reads at fixed addresses in a fixed order, then a write carrying a protection byte, then a write carrying the complement of that byte. When the whole pattern arrives without a fault, the block loads the byte into an 8-bit protect register. Each bit of that register guards one 32K-word sector. Any deviation from the pattern abandons the attempt and leaves the register as it was.

The reads in the pattern are ordinary accesses, and the memory serves them as usual. The block only observes them. On every write cycle the block produces a qualifier that tells the array whether the write may land. The qualifier is low for writes into protected sectors and for the two writes that carry the protection value. A synchronous reset loads the register with a parameter value. That value stands in for a setting that would normally be kept across power loss.

Top module: `sector_lock_guard`

## Requirements
- R1: While reset is applied and on the cycle after it, `protect` equals the `PROT_DEFAULT` parameter (00h by default). After reset, `weAllowed` is low until a write cycle arrives.
- R2: `weAllowed` is high only in the clock cycle in which a new write access starts (`chipEnN`=0, `writeN`=0) to an unprotected sector. It is low for reads and for cycles with `chipEnN`=1.
- R3: Sector n covers the word addresses n*8000h to n*8000h+7FFFh, so the sector number is `addr[17:15]`. Bit n of `protect` = 1 blocks writes to sector n, and 0 allows them. A blocked write does not change the word it targets.
- R4: The protect register takes a new value in the cycle after the confirming write, when all of the following arrive in order: a chip-enable falling edge on a read of 24555h, reads of 3AAAAh, 02333h, 1CCCCh, 000FFh and 3EF00h, a write whose `dataIn[7:0]` is the value V, and a write whose `dataIn[7:0]` is ~V.
- R5: If chip enable is already low when the pattern starts, a read of 00000h must come just before the read of 24555h. Without that read, and without a chip-enable falling edge, the read of 24555h does not start the pattern.
- R6: A read at an address that is not the next one in the pattern abandons the attempt, and `protect` stays unchanged.
- R7: A seventh read in the place where the value write is expected abandons the attempt, and `protect` stays unchanged.
- R8: If the confirming write's low byte is not the exact complement of the held value, `protect` stays unchanged. `dataIn[15:8]` and the address of both setting writes are ignored.
- R9: The value write and the confirming write always give `weAllowed`=0, even when they target an unprotected sector and even when the confirmation fails.
- R10: A new access starts on a chip-enable falling edge, or on a change of `addr` or `writeN` while chip enable stays low. Holding the same address and direction for more than one clock is a single access.
- R11: After an abandoned attempt, a full correct pattern that follows at once is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the bus is sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| chipEnN | input | 1 | Chip enable, active low |
| writeN | input | 1 | Direction: 1 = read, 0 = write |
| addr | input | 18 | Word address |
| dataIn | input | 16 | Write data bus; only the low byte matters to the sequencer |
| protect | output | 8 | Per-sector protect register |
| weAllowed | output | 1 | Qualifier for the array write in the current cycle |

## Verification
The hardest situation to reach is the start of the pattern while chip enable is already low. The read of 24555h then counts only after a read of 00000h, and it must not count without that read. To get there, the stimulus holds chip enable low through an unrelated read and then runs the pattern twice: once without the 00000h read, where nothing may change, and once with it, where the new value must load. Attempts that are swapped, too long or wrongly confirmed are placed directly before valid ones, so that the return to the start state is also exercised.

// File: rtl/slg_pkg.sv
package slg_pkg;

  localparam int ADDR_W   = 18;
  localparam int DATA_W   = 16;
  localparam int PROT_W   = 8;
  localparam int NUM_KEYS = 7;   // index 0: optional lead-in, 1..6: ordered pattern
  localparam int KEY_IDX_W = $clog2(NUM_KEYS);

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PRE,
    ST_K1,
    ST_K2,
    ST_K3,
    ST_K4,
    ST_K5,
    ST_DATA,
    ST_CONF
  } seqStateT;

  // control -> datapath
  typedef struct packed {
    logic loadPending;
    logic commit;
    logic suppressWe;
  } ctrlStrobeT;

  // datapath -> control
  typedef struct packed {
    logic                newCycle;
    logic                isWrite;
    logic                ceFell;
    logic [NUM_KEYS-1:0] keyHit;
    logic                complOk;
  } busObsT;

  function automatic logic [ADDR_W-1:0] keyAddr(input int idx);
    logic [ADDR_W-1:0] a;
    case (idx)
      0:       a = 18'h00000;
      1:       a = 18'h24555;
      2:       a = 18'h3AAAA;
      3:       a = 18'h02333;
      4:       a = 18'h1CCCC;
      5:       a = 18'h000FF;
      default: a = 18'h3EF00;
    endcase
    return a;
  endfunction

endpackage

// File: rtl/slg_datapath.sv
module slg_datapath
  import slg_pkg::*;
#(
  parameter logic [PROT_W-1:0] PROT_DEFAULT = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chipEnN,
  input  logic              writeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  input  ctrlStrobeT        strb,
  output busObsT            obs,
  output logic [PROT_W-1:0] protect,
  output logic              weAllowed
);

  localparam int SECT_W = $clog2(PROT_W);

  logic                prevCeNQ;
  logic                prevWrNQ;
  logic [ADDR_W-1:0]   prevAddrQ;
  logic [PROT_W-1:0]   pendingQ;
  logic [PROT_W-1:0]   protectQ;
  logic [NUM_KEYS-1:0] keyHit;
  logic [SECT_W-1:0]   sectIdx;
  logic                newCycle;
  logic                ceFell;
  logic                complOk;
  logic                unusedHighByte;

  assign unusedHighByte = ^dataIn[DATA_W-1:PROT_W];

  // access boundary detection
  always_ff @(posedge clk) begin
    if (rst) begin
      prevCeNQ  <= 1'b1;
      prevWrNQ  <= 1'b1;
      prevAddrQ <= '0;
    end else begin
      prevCeNQ  <= chipEnN;
      prevWrNQ  <= writeN;
      prevAddrQ <= addr;
    end
  end

  assign ceFell   = !chipEnN && prevCeNQ;
  assign newCycle = !chipEnN && (prevCeNQ || (addr != prevAddrQ) || (writeN != prevWrNQ));

  // pattern address comparators
  for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
    assign keyHit[k] = (addr == keyAddr(k));
  end

  // pending value and protect register
  always_ff @(posedge clk) begin
    if (rst) begin
      pendingQ <= '0;
      protectQ <= PROT_DEFAULT;
    end else begin
      if (strb.loadPending) pendingQ <= dataIn[PROT_W-1:0];
      if (strb.commit)      protectQ <= pendingQ;
    end
  end

  assign complOk = (dataIn[PROT_W-1:0] == ~pendingQ);

  assign obs = '{newCycle: newCycle,
                 isWrite:  !writeN,
                 ceFell:   ceFell,
                 keyHit:   keyHit,
                 complOk:  complOk};

  assign sectIdx   = addr[ADDR_W-1 -: SECT_W];
  assign protect   = protectQ;
  assign weAllowed = newCycle && !writeN && !protectQ[sectIdx] && !strb.suppressWe;

  // R1: reset loads the stand-in setting
  p_reset_default_r1: assert property (@(posedge clk)
    $past(rst) |-> (protectQ == PROT_DEFAULT));

  // R6, R7, R8: register moves only on a commit from the sequencer
  p_hold_unless_commit_r6: assert property (@(posedge clk) disable iff (rst)
    !strb.commit |=> $stable(protectQ));

  // R3: no write qualifier into a protected sector
  p_we_open_sector_r3: assert property (@(posedge clk) disable iff (rst)
    weAllowed |-> !protect[addr[ADDR_W-1 -: SECT_W]]);

  // R2: qualifier only for enabled write cycles
  p_we_is_write_r2: assert property (@(posedge clk) disable iff (rst)
    weAllowed |-> (!chipEnN && !writeN));

endmodule

// File: rtl/slg_ctrl.sv
module slg_ctrl
  import slg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  busObsT     obs,
  output ctrlStrobeT strb
);

  seqStateT stateQ;
  seqStateT stateD;

  // where a cycle that breaks the pattern may still begin a new one
  function automatic seqStateT restartFrom(input busObsT o);
    seqStateT s;
    s = ST_IDLE;
    if (!o.isWrite && o.keyHit[0])
      s = ST_PRE;
    else if (!o.isWrite && o.keyHit[1] && o.ceFell)
      s = ST_K1;
    return s;
  endfunction

  function automatic logic [KEY_IDX_W-1:0] wantedKey(input seqStateT s);
    logic [KEY_IDX_W-1:0] k;
    case (s)
      ST_PRE:  k = KEY_IDX_W'(1);
      ST_K1:   k = KEY_IDX_W'(2);
      ST_K2:   k = KEY_IDX_W'(3);
      ST_K3:   k = KEY_IDX_W'(4);
      ST_K4:   k = KEY_IDX_W'(5);
      ST_K5:   k = KEY_IDX_W'(6);
      default: k = KEY_IDX_W'(0);
    endcase
    return k;
  endfunction

  function automatic seqStateT stepOf(input seqStateT s);
    seqStateT n;
    case (s)
      ST_PRE:  n = ST_K1;
      ST_K1:   n = ST_K2;
      ST_K2:   n = ST_K3;
      ST_K3:   n = ST_K4;
      ST_K4:   n = ST_K5;
      ST_K5:   n = ST_DATA;
      default: n = ST_IDLE;
    endcase
    return n;
  endfunction

  always_comb begin
    stateD = stateQ;
    strb   = '0;
    if (obs.newCycle) begin
      case (stateQ)
        ST_IDLE: stateD = restartFrom(obs);
        ST_DATA: begin
          if (obs.isWrite) begin
            strb.loadPending = 1'b1;
            strb.suppressWe  = 1'b1;
            stateD           = ST_CONF;
          end else begin
            stateD = restartFrom(obs);
          end
        end
        ST_CONF: begin
          if (obs.isWrite) begin
            strb.suppressWe = 1'b1;
            strb.commit     = obs.complOk;
            stateD          = ST_IDLE;
          end else begin
            stateD = restartFrom(obs);
          end
        end
        default: begin
          if (!obs.isWrite && obs.keyHit[wantedKey(stateQ)])
            stateD = stepOf(stateQ);
          else
            stateD = restartFrom(obs);
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) stateQ <= ST_IDLE;
    else     stateQ <= stateD;
  end

  // R4: confirmation stage is only entered from the value stage
  p_conf_from_data_r4: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_CONF) |-> ($past(stateQ) == ST_DATA || $past(stateQ) == ST_CONF));

  // R9: a setting write never both holds and commits
  p_strobe_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.loadPending, strb.commit}));

  // R9: commit only comes with a suppressed write
  p_commit_suppressed_r9: assert property (@(posedge clk) disable iff (rst)
    strb.commit |-> (strb.suppressWe && obs.isWrite));

endmodule

// File: rtl/sector_lock_guard.sv
module sector_lock_guard
  import slg_pkg::*;
#(
  parameter logic [PROT_W-1:0] PROT_DEFAULT = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chipEnN,
  input  logic              writeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [PROT_W-1:0] protect,
  output logic              weAllowed
);

  ctrlStrobeT strb;
  busObsT     obs;

  slg_ctrl u_ctrl (
    .clk  (clk),
    .rst  (rst),
    .obs  (obs),
    .strb (strb)
  );

  slg_datapath #(
    .PROT_DEFAULT (PROT_DEFAULT)
  ) u_datapath (
    .clk       (clk),
    .rst       (rst),
    .chipEnN   (chipEnN),
    .writeN    (writeN),
    .addr      (addr),
    .dataIn    (dataIn),
    .strb      (strb),
    .obs       (obs),
    .protect   (protect),
    .weAllowed (weAllowed)
  );

endmodule

// File: tb/sector_lock_guard_tb.sv
`timescale 1ns/100ps
module sector_lock_guard_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        chipEnN = 1'b1;
  logic        writeN = 1'b1;
  logic [17:0] addr = '0;
  logic [15:0] dataIn = '0;
  logic [7:0]  protect;
  logic        weAllowed;

  always #2.5 clk = ~clk;

  sector_lock_guard u_dut (
    .clk(clk), .rst(rst), .chipEnN(chipEnN), .writeN(writeN),
    .addr(addr), .dataIn(dataIn), .protect(protect), .weAllowed(weAllowed)
  );

  typedef struct {
    string       tag;
    logic        expWe;
    logic [7:0]  expProt;
    logic [17:0] a;
    logic [15:0] d;
  } itemT;

  itemT        sbq[$];
  logic [15:0] mem [int];
  int          vectors = 0;
  int          miscompares = 0;
  logic [7:0]  tbProt = 8'h00;
  logic        pCe = 1'b1;
  logic        pW = 1'b1;
  logic [17:0] pA = '0;
  bit          done = 0;

  // monitor: one item per cycle, compared mid-cycle
  initial begin
    forever begin
      @(negedge clk);
      if (sbq.size() > 0) begin
        itemT it;
        it = sbq.pop_front();
        vectors++;
        if (weAllowed !== it.expWe || protect !== it.expProt) begin
          miscompares++;
          $display("FAIL %s: weAllowed=%b protect=%h, expected weAllowed=%b protect=%h",
                   it.tag, weAllowed, protect, it.expWe, it.expProt);
        end
        if (weAllowed === 1'b1) mem[int'(it.a)] = it.d;
      end
    end
  end

  // driver: one bus cycle, expected qualifier from the requirements (R2, R3, R9, R10)
  task automatic cyc(input logic ceN, input logic wn, input logic [17:0] a,
                     input logic [15:0] d, input logic setW, input string tag);
    itemT it;
    logic nc;
    @(posedge clk); #1;
    chipEnN = ceN; writeN = wn; addr = a; dataIn = d;
    nc = !ceN && (pCe || a != pA || wn != pW);
    it.tag     = tag;
    it.expWe   = nc && !wn && !tbProt[a[17:15]] && !setW;
    it.expProt = tbProt;
    it.a       = a;
    it.d       = d;
    sbq.push_back(it);
    pCe = ceN; pA = a; pW = wn;
  endtask

  task automatic runSeq(input bit prefix, input bit holdCe, input bit swapOrder,
                        input bit extraRead, input logic [7:0] val,
                        input logic [7:0] conf, input string tag);
    logic [17:0] keys [6];
    bit valid;
    keys[0] = 18'h24555; keys[1] = 18'h3AAAA; keys[2] = 18'h02333;
    keys[3] = 18'h1CCCC; keys[4] = 18'h000FF; keys[5] = 18'h3EF00;
    if (holdCe) cyc(1'b0, 1'b1, 18'h00100, '0, 1'b0, tag);
    else        cyc(1'b1, 1'b1, 18'h00000, '0, 1'b0, tag);
    if (prefix) cyc(1'b0, 1'b1, 18'h00000, '0, 1'b0, tag);
    for (int i = 0; i < 6; i++) begin
      logic [17:0] k;
      k = keys[i];
      if (swapOrder && i == 1) k = keys[2];
      if (swapOrder && i == 2) k = keys[1];
      cyc(1'b0, 1'b1, k, '0, 1'b0, tag);
    end
    if (extraRead) cyc(1'b0, 1'b1, 18'h3FFFF, '0, 1'b0, tag);
    valid = !swapOrder && !extraRead && (prefix || !holdCe);
    cyc(1'b0, 1'b0, 18'h11111, {8'hA5, val}, valid, tag);
    cyc(1'b0, 1'b0, 18'h22222, {8'h3C, conf}, valid, tag);
    if (valid && conf == ~val) tbProt = val;
  endtask

  task automatic sectorSweep(input logic [15:0] base, input string tag);
    for (int s = 0; s < 8; s++)
      cyc(1'b0, 1'b0, 18'(s * 32'h8000 + 32'h10), base + 16'(s), 1'b0, tag);
  endtask

  task automatic directCheck(input bit cond, input string tag, input logic [15:0] act,
                             input logic [15:0] exp);
    vectors++;
    if (!cond) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drain();
    while (sbq.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic applyReset(input string tag);
    drain();
    @(posedge clk); #1;
    rst = 1'b1; chipEnN = 1'b1; writeN = 1'b1; addr = '0; dataIn = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    directCheck(protect === 8'h00 && weAllowed === 1'b0, tag,
                {7'd0, weAllowed, protect}, 16'h0000);
    @(posedge clk); #1;
    rst = 1'b0;
    tbProt = 8'h00; pCe = 1'b1; pW = 1'b1; pA = '0;
    @(negedge clk);
    directCheck(protect === 8'h00, tag, {8'd0, protect}, 16'h0000);
  endtask

  initial begin
    applyReset("R1 reset state");

    // R2 R3: all sectors open by default
    cyc(1'b1, 1'b1, '0, '0, 1'b0, "R2 idle");
    sectorSweep(16'h1000, "R3 open sector writes");
    cyc(1'b0, 1'b1, 18'h04000, '0, 1'b0, "R2 read gives no qualifier");

    // R10: same write held is one access
    cyc(1'b0, 1'b0, 18'h00050, 16'h0050, 1'b0, "R10 first clock of write");
    cyc(1'b0, 1'b0, 18'h00050, 16'h0050, 1'b0, "R10 held write");
    cyc(1'b1, 1'b0, 18'h00050, 16'h0050, 1'b0, "R2 write with chip disabled");

    // R4: correct unlock protecting sectors 0 and 7
    runSeq(0, 0, 0, 0, 8'h81, 8'h7E, "R4 correct unlock");
    cyc(1'b1, 1'b1, '0, '0, 1'b0, "R4 value visible");
    sectorSweep(16'h2000, "R3 writes after protect 81h");
    cyc(1'b0, 1'b1, 18'h00000, '0, 1'b0, "R3 spacer");
    cyc(1'b0, 1'b0, 18'h00010, 16'hBEEF, 1'b0, "R3 protected write");
    drain();
    directCheck(mem.exists(32'h10) && mem[32'h10] === 16'h1000, "R3 protected word unchanged",
                mem.exists(32'h10) ? mem[32'h10] : 16'hxxxx, 16'h1000);
    directCheck(mem.exists(32'h8010) && mem[32'h8010] === 16'h2001, "R3 open word written",
                mem.exists(32'h8010) ? mem[32'h8010] : 16'hxxxx, 16'h2001);

    // R8 then R11: wrong complement, immediate retry
    runSeq(0, 0, 0, 0, 8'hFF, 8'h01, "R8 wrong complement");
    runSeq(0, 0, 0, 0, 8'h42, 8'hBD, "R11 retry after abort");
    cyc(1'b1, 1'b1, '0, '0, 1'b0, "R11 value visible");

    // R6, R7: broken patterns leave 42h
    runSeq(0, 0, 1, 0, 8'h00, 8'hFF, "R6 swapped order");
    runSeq(0, 0, 0, 1, 8'h00, 8'hFF, "R7 seventh read");
    cyc(1'b1, 1'b1, '0, '0, 1'b0, "R7 value kept");

    // R5: chip enable held low
    runSeq(0, 1, 0, 0, 8'h00, 8'hFF, "R5 no lead-in read");
    runSeq(1, 1, 0, 0, 8'h0C, 8'hF3, "R5 lead-in read");
    cyc(1'b1, 1'b1, '0, '0, 1'b0, "R5 value visible");
    sectorSweep(16'h3000, "R3 writes after protect 0Ch");

    applyReset("R1 reset after protect");

    drain();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #500us;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule